// File: doc/BRIEF.md
# Power-down and wake-up controller

This block stops the core's clock on a halt command and restarts it when a wake cause arrives. While halted, only the system-clock enable is dropped. The watchdog's own clock path is outside this gating, so an overflow can still come in. Four causes end the halt: an external reset request, an interrupt request, a falling edge on an enabled pin of an 8-bit wake port, and a watchdog overflow. When one of them ends the halt, the block emits a one-cycle resume event with an action code. The code tells the core whether to continue at the next instruction, take the interrupt vector, do a warm restart (program counter and stack pointer only) or run a full initialization.

The block also keeps two status flags that software reads after a restart to find its cause. The power-down flag marks that a halt was entered. The timeout flag marks a watchdog overflow. No data stream passes through the block. Every pin is a plain level or a one-cycle strobe, so there is no valid/ready pair and no back-pressure: the core must act on a resume event in the cycle it is shown.

Top module: `pdwake_ctrl`

## Requirements
- R1: A halt_cmd strobe while running drives sys_clk_en low from the next cycle, provided neither ext_rst nor wdt_ovf is high in the same cycle. sys_clk_en stays low until a wake cause is taken.
- R2: Entering halt sets pd_flag to 1 and clears to_flag to 0.
- R3: An active-low power-on reset (rst_n) clears pd_flag and to_flag and leaves the block running. A clr_wdt strobe clears pd_flag in the next cycle, unless a halt is entered in the same cycle.
- R4: While halted, a high-to-low transition on wake_pins[i] with wake_mask[i]=1 ends the halt with action NEXT (code 1). The resume event appears three clock edges after the pin changes: two synchronizer flops, then the edge register. A falling edge on an unmasked pin, and any rising edge, leaves the block halted.
- R5: While halted, irq_req ends the halt. The action is VECTOR (code 2) when irq_en=1 and stack_full=0. Otherwise, when the interrupt is disabled or the stack is full, the action is NEXT (code 1).
- R6: While halted, wdt_ovf ends the halt with action WARM (code 3). It sets to_flag and leaves pd_flag unchanged.
- R7: ext_rst, halted or running, produces action FULL (code 4), ends any halt and leaves both flags unchanged.
- R8: While running, wdt_ovf produces action FULL (code 4) and sets to_flag.
- R9: When causes coincide, exactly one action is taken, chosen in this order: ext_rst first, then wdt_ovf, then irq_req, then a port edge.
- R10: While running, irq_req and port edges produce no resume event.
- R11: A resume event is a one-cycle pulse on resume_vld, with resume_act valid, in the cycle after the cause is sampled. sys_clk_en is high in that same cycle. Action NONE is code 0 and never appears with resume_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| halt_cmd | input | 1 | One-cycle strobe: enter halt |
| clr_wdt | input | 1 | One-cycle strobe: clear-watchdog command |
| ext_rst | input | 1 | External reset request, synchronous to clk |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable of the core |
| stack_full | input | 1 | Core return stack has no free entry |
| wake_pins | input | 8 | Asynchronous wake port pins, idle high |
| wake_mask | input | 8 | Per-pin wake enable |
| sys_clk_en | output | 1 | System clock enable, low while halted |
| resume_vld | output | 1 | One-cycle resume event |
| resume_act | output | 3 | Resume action: 0 none, 1 next, 2 vector, 3 warm, 4 full |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Timeout status flag |

## Verification
The assertions check the following on every cycle: clock gating and flag setting on halt entry, flag clearing by clr_wdt, warm restart with the timeout flag on a halted overflow, the full action on an external reset, the absence of resume events while running without a reset cause, and that the clock is re-enabled with every event. Some properties depend on a chosen sequence of events and can only be shown by the bench scenarios. These are the three-edge latency of a port wake, the rejection of unmasked pins and rising edges, the split of an interrupt wake into next or vector by enable and stack state, and the priority among coinciding causes.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int ACT_W = 3;
  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 3'd0,
    ACT_NEXT   = 3'd1,
    ACT_VECTOR = 3'd2,
    ACT_WARM   = 3'd3,
    ACT_FULL   = 3'd4
  } resume_act_e;
endpackage

// File: rtl/pdw_port_edge.sv
module pdw_port_edge #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] mask,
  output logic              fall_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][PORT_W-1:0] chain;
  logic [PORT_W-1:0]                  prev_q;

  // Pins idle high, so reset to ones to avoid a false edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      prev_q <= '1;
    end else begin
      chain[0] <= pins;
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[LAST];
    end
  end

  assign fall_hit = |(prev_q & ~chain[LAST] & mask);
endmodule

// File: rtl/pdw_resolver.sv
module pdw_resolver
  import pdw_pkg::*;
(
  input  logic        halted,
  input  logic        ext_rst,
  input  logic        wdt_ovf,
  input  logic        irq_req,
  input  logic        irq_en,
  input  logic        stack_full,
  input  logic        port_wake,
  output resume_act_e act
);
  // Fixed order: external reset, watchdog, interrupt, port edge (R9).
  always_comb begin
    act = ACT_NONE;
    if (ext_rst)                   act = ACT_FULL;
    else if (wdt_ovf)              act = halted ? ACT_WARM : ACT_FULL;
    else if (halted && irq_req)    act = (irq_en && !stack_full) ? ACT_VECTOR : ACT_NEXT;
    else if (halted && port_wake)  act = ACT_NEXT;
  end
endmodule

// File: rtl/pdw_flags.sv
module pdw_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_enter,
  input  logic clr_req,
  input  logic timeout_hit,
  output logic pd_q,
  output logic to_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else if (halt_enter) begin
      pd_q <= 1'b1;
      to_q <= 1'b0;
    end else begin
      if (clr_req)     pd_q <= 1'b0;
      if (timeout_hit) to_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdw_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_cmd,
  input  logic              clr_wdt,
  input  logic              ext_rst,
  input  logic              wdt_ovf,
  input  logic              irq_req,
  input  logic              irq_en,
  input  logic              stack_full,
  input  logic [PORT_W-1:0] wake_pins,
  input  logic [PORT_W-1:0] wake_mask,
  output logic              sys_clk_en,
  output logic              resume_vld,
  output logic [ACT_W-1:0]  resume_act,
  output logic              pd_flag,
  output logic              to_flag
);
  logic        halted_q;
  logic        port_wake;
  logic        halt_enter;
  resume_act_e act_next;

  pdw_port_edge #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins(wake_pins), .mask(wake_mask), .fall_hit(port_wake)
  );

  pdw_resolver u_res (
    .halted(halted_q), .ext_rst(ext_rst), .wdt_ovf(wdt_ovf), .irq_req(irq_req),
    .irq_en(irq_en), .stack_full(stack_full), .port_wake(port_wake), .act(act_next)
  );

  // A reset cause in the same cycle wins over halt entry.
  assign halt_enter = halt_cmd && !halted_q && !ext_rst && !wdt_ovf;

  pdw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .halt_enter(halt_enter), .clr_req(clr_wdt),
    .timeout_hit(wdt_ovf && !ext_rst), .pd_q(pd_flag), .to_q(to_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q   <= 1'b0;
      resume_vld <= 1'b0;
      resume_act <= ACT_NONE;
    end else begin
      if (act_next != ACT_NONE) halted_q <= 1'b0;
      else if (halt_enter)      halted_q <= 1'b1;
      resume_vld <= (act_next != ACT_NONE);
      resume_act <= act_next;
    end
  end

  assign sys_clk_en = !halted_q;

  a_r1_halt_gates_clock: assert property (@(posedge clk) disable iff (!rst_n)
    halt_cmd && sys_clk_en && !ext_rst && !wdt_ovf |=> !sys_clk_en && pd_flag && !to_flag);

  a_r3_clear_pd: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt && !(halt_cmd && sys_clk_en) |=> !pd_flag);

  a_r6_warm_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en && wdt_ovf && !ext_rst |=> resume_vld && resume_act == ACT_WARM && to_flag);

  a_r7_full_on_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> resume_vld && resume_act == ACT_FULL && sys_clk_en);

  a_r10_quiet_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en && !ext_rst && !wdt_ovf |=> !resume_vld);

  a_r11_event_reenables: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld |-> sys_clk_en && resume_act != ACT_NONE);
endmodule

// File: tb/pdwake_ctrl_tb.sv
module pdwake_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_cmd = 0, clr_wdt = 0, ext_rst = 0, wdt_ovf = 0;
  logic       irq_req = 0, irq_en = 0, stack_full = 0;
  logic [7:0] wake_pins = 8'hFF, wake_mask = 8'h01;
  logic       sys_clk_en, resume_vld, pd_flag, to_flag;
  logic [2:0] resume_act;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int act; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  pdwake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .clr_wdt(clr_wdt), .ext_rst(ext_rst),
    .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
    .wake_pins(wake_pins), .wake_mask(wake_mask), .sys_clk_en(sys_clk_en),
    .resume_vld(resume_vld), .resume_act(resume_act), .pd_flag(pd_flag), .to_flag(to_flag)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_act(int act, string tag);
    exp_t e;
    e.act = act; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: every resume event must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && resume_vld) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10/R11 unexpected event actual=%0d expected=none", resume_act);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (int'(resume_act) != e.act) begin
          errors++;
          $display("FAIL %s actual=%0d expected=%0d", e.tag, resume_act, e.act);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_halt();
    @(negedge clk) halt_cmd = 1;
    @(negedge clk) halt_cmd = 0;
  endtask

  task automatic irq_pulse(logic en, logic sf);
    @(negedge clk) begin irq_req = 1; irq_en = en; stack_full = sf; end
    @(negedge clk) irq_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R3 reset clk_en", sys_clk_en, 1);
    chk("R3 reset pd", pd_flag, 0);
    chk("R3 reset to", to_flag, 0);

    enter_halt();
    chk("R1 clk_en off", sys_clk_en, 0);
    chk("R2 pd set", pd_flag, 1);
    chk("R2 to clear", to_flag, 0);

    // R4 unmasked pin falls, then rises: stays halted
    @(negedge clk) wake_pins[3] = 0;
    cyc(5);
    chk("R4 unmasked ignored", sys_clk_en, 0);
    @(negedge clk) wake_pins[3] = 1;
    cyc(5);
    chk("R4 rising ignored", sys_clk_en, 0);

    // R4 masked falling edge: resume after three edges
    expect_act(1, "R4 port next");
    @(negedge clk) wake_pins[0] = 0;
    cyc(2);
    chk("R4 still halted at 2", sys_clk_en, 0);
    cyc(1);
    chk("R11 clk_en back", sys_clk_en, 1);
    @(negedge clk) wake_pins[0] = 1;
    cyc(4);

    // R5 interrupt variants
    enter_halt();
    expect_act(1, "R5 irq disabled");
    irq_pulse(0, 0);
    chk("R5 clk_en after irq", sys_clk_en, 1);
    enter_halt();
    expect_act(1, "R5 stack full");
    irq_pulse(1, 1);
    enter_halt();
    expect_act(2, "R5 vector");
    irq_pulse(1, 0);

    // R3 clear-watchdog clears pd
    chk("R3 pd before clr", pd_flag, 1);
    @(negedge clk) clr_wdt = 1;
    @(negedge clk) clr_wdt = 0;
    chk("R3 pd cleared", pd_flag, 0);

    // R6 watchdog during halt
    enter_halt();
    expect_act(3, "R6 warm");
    @(negedge clk) wdt_ovf = 1;
    @(negedge clk) wdt_ovf = 0;
    chk("R6 to set", to_flag, 1);
    chk("R6 pd kept", pd_flag, 1);

    // R7 external reset during halt
    enter_halt();
    chk("R2 to cleared on halt", to_flag, 0);
    expect_act(4, "R7 full");
    @(negedge clk) ext_rst = 1;
    @(negedge clk) ext_rst = 0;
    chk("R7 pd unchanged", pd_flag, 1);
    chk("R7 to unchanged", to_flag, 0);
    chk("R7 clk_en", sys_clk_en, 1);

    // R8 watchdog while running
    expect_act(4, "R8 full running");
    @(negedge clk) wdt_ovf = 1;
    @(negedge clk) wdt_ovf = 0;
    chk("R8 to set", to_flag, 1);

    // R9 priority: ext over wdt and irq
    enter_halt();
    expect_act(4, "R9 ext first");
    @(negedge clk) begin ext_rst = 1; wdt_ovf = 1; irq_req = 1; irq_en = 1; stack_full = 0; end
    @(negedge clk) begin ext_rst = 0; wdt_ovf = 0; irq_req = 0; end
    chk("R9 to unchanged by ext", to_flag, 0);
    // wdt over irq
    enter_halt();
    expect_act(3, "R9 wdt over irq");
    @(negedge clk) begin wdt_ovf = 1; irq_req = 1; end
    @(negedge clk) begin wdt_ovf = 0; irq_req = 0; end
    // irq over port edge
    enter_halt();
    expect_act(2, "R9 irq over port");
    @(negedge clk) wake_pins[0] = 0;
    cyc(2);
    irq_req = 1;
    @(negedge clk) irq_req = 0;
    chk("R9 single event resumed", sys_clk_en, 1);
    cyc(2);
    @(negedge clk) wake_pins[0] = 1;
    cyc(4);

    // R10 running: irq and port edge give nothing
    @(negedge clk) begin irq_req = 1; wake_pins[0] = 0; end
    @(negedge clk) irq_req = 0;
    cyc(5);
    chk("R10 clk_en stays", sys_clk_en, 1);
    chk("R10 no event", resume_vld, 0);
    @(negedge clk) wake_pins[0] = 1;
    cyc(5);

    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      errors++;
      $display("FAIL %s actual=missing expected=%0d", e.tag, e.act);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule